// File: doc/BRIEF.md
# Programmable Countdown Timer with Level Interrupt

This block counts down from a loaded value, one step for each pulse of an external one-microsecond tick strobe. Software programs it through a single control word that carries the reload value, a periodic-mode flag and a run flag, all taken in the same write. When the count has reached zero and one more tick arrives, the timer expires. An expiry sets a pending flag, which drives an active-high, level-sensitive interrupt line.

In periodic mode the count reloads on expiry and the timer keeps running, so a load value of N gives an interrupt every N+1 ticks. For example, a load of 9999 with 1 µs ticks gives a 10 ms period. In one-shot mode the timer stops after its first expiry and stays stopped until the control word is written again. A second write address acts as an acknowledge register: writing a one to bit 0 there drops the pending flag. A status word reports the live count and the pending flag.

Top module: `cdtimer`

## Requirements
- R1: After reset the timer is stopped, the count is 0 and the interrupt is low.
- R2: A write to address 0 takes the count from bits [28:0], periodic mode from bit 30 and run from bit 31, all in one step. The new count appears in the status one cycle after the write.
- R3: While running, the count falls by one on each cycle with the tick high. Without a tick, or while stopped, the count holds.
- R4: A running timer whose count is 0 expires on the next tick and sets the interrupt. A load of N therefore expires N+1 ticks after the write.
- R5: In periodic mode an expiry reloads the last loaded value and the timer keeps running.
- R6: In one-shot mode an expiry stops the timer with the count at 0. Further ticks neither change the count nor expire again until address 0 is rewritten.
- R7: Writing the value 0 to address 0 stops the timer and sets the count to 0.
- R8: A write to address 1 with bit 0 set clears the interrupt. The same write with bit 0 clear has no effect.
- R9: If an expiry and a clear happen in the same cycle, the interrupt stays set.
- R10: The interrupt is a level: once set, it stays high until it is cleared.
- R11: Status bit 31 is the pending flag and bits [28:0] are the count. Bits 30:29 read 0.
- R12: A write to address 0 in a cycle with the tick high takes effect as written. That tick neither decrements the count nor causes an expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe, once per microsecond |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control word, 1 = interrupt clear |
| wr_data | input | 32 | Write data |
| irq | output | 1 | Level-high interrupt, the pending flag |
| status | output | 32 | {pending, 2'b0, count} |

## Verification
A wrong count, reload value or mode shows in the status count one cycle after the tick that used it. A lost run flag shows as a count that stops falling on the next tick. A reload or one-shot fault surfaces as the interrupt rising at the wrong tick, or rising again after it should have stopped. The bench compares both outputs to a behavioural model on every clock, so any divergence is reported in the cycle in which it first reaches a port.

// File: rtl/cdtimer.sv
module cdtimer #(
  parameter int CW = 29
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [31:0] wr_data,
  output logic        irq,
  output logic [31:0] status
);
  localparam int PADW = 31 - CW;

  logic [CW-1:0] cnt_q, load_q;
  logic          en_q, per_q, irq_q;
  logic          ctrl_wr, clr_wr, fire, unused_bits;

  assign ctrl_wr = wr_en && !wr_addr;
  assign clr_wr  = wr_en && wr_addr && wr_data[0];
  assign fire    = tick && en_q && !ctrl_wr && (cnt_q == '0);
  assign unused_bits = ^wr_data[29:CW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      load_q <= '0;
      en_q   <= 1'b0;
      per_q  <= 1'b0;
    end else if (ctrl_wr) begin
      cnt_q  <= wr_data[CW-1:0];
      load_q <= wr_data[CW-1:0];
      per_q  <= wr_data[30];
      en_q   <= wr_data[31];
    end else if (fire) begin
      if (per_q) cnt_q <= load_q;
      else       en_q  <= 1'b0;
    end else if (tick && en_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (fire)   irq_q <= 1'b1;
    else if (clr_wr) irq_q <= 1'b0;
  end

  assign irq    = irq_q;
  assign status = {irq_q, {PADW{1'b0}}, cnt_q};
endmodule

// File: rtl/cdtimer_chk.sv
module cdtimer_chk #(
  parameter int CW = 29
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          ctrl_wr,
  input logic          clr_wr,
  input logic          en_q,
  input logic          per_q,
  input logic [CW-1:0] cnt_q,
  input logic [31:0]   wr_data,
  input logic          irq,
  input logic [31:0]   status
);
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (cnt_q == $past(wr_data[CW-1:0])) && (en_q == $past(wr_data[31])));

  assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en_q && !ctrl_wr && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ctrl_wr) |=> $stable(cnt_q));

  assert_expiry_sets_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en_q && !ctrl_wr && cnt_q == '0) |=> irq);

  assert_oneshot_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en_q && !per_q && !ctrl_wr && cnt_q == '0) |=> !en_q && cnt_q == '0);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !(tick && en_q && !ctrl_wr && cnt_q == '0)) |=> !irq);

  assert_level_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq);

  always_comb begin
    if (rst_n) assert_status_fmt_R11: assert (status[31] == irq && status[30:CW] == '0);
  end
endmodule

bind cdtimer cdtimer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_wr(ctrl_wr), .clr_wr(clr_wr),
  .en_q(en_q), .per_q(per_q), .cnt_q(cnt_q), .wr_data(wr_data),
  .irq(irq), .status(status)
);

// File: tb/tb_cdtimer.sv
`timescale 1ns/1ps
module tb_cdtimer;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic irq;
  logic [31:0] status;
  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cdtimer dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
               .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq), .status(status));

  // behavioural reference
  int m_cnt = 0, m_load = 0;
  bit m_en = 0, m_per = 0, m_irq = 0;
  always @(posedge clk) begin
    bit wctl, clr, exp_now;
    wctl = wr_en && !wr_addr;
    clr  = wr_en && wr_addr && wr_data[0];
    exp_now = tick && m_en && !wctl && m_cnt == 0;
    if (!rst_n) begin
      m_cnt <= 0; m_load <= 0; m_en <= 0; m_per <= 0; m_irq <= 0;
    end else begin
      if (wctl) begin
        m_cnt <= int'(wr_data[28:0]); m_load <= int'(wr_data[28:0]);
        m_per <= wr_data[30]; m_en <= wr_data[31];
      end else if (exp_now) begin
        if (m_per) m_cnt <= m_load; else m_en <= 0;
      end else if (tick && m_en) m_cnt <= m_cnt - 1;
      if (exp_now) m_irq <= 1; else if (clr) m_irq <= 0;
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
    end
  endtask

  // per-cycle model comparison (R11 status layout, R10 level)
  always @(negedge clk) if (rst_n && !done) begin
    chk("R11 status vs model", status, {m_irq, 2'b00, m_cnt[28:0]});
    chk("R10 irq vs model", {31'b0, irq}, {31'b0, m_irq});
  end

  task automatic cyc(bit t, bit we = 0, bit a = 0, logic [31:0] d = 0);
    tick = t; wr_en = we; wr_addr = a; wr_data = d;
    @(negedge clk);
    tick = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 reset status", status, 32'h0);
    chk("R1 reset irq", {31'b0, irq}, 32'h0);
    cyc(1); cyc(1);
    chk("R1 stopped after reset", status, 32'h0);

    // one-shot, load 3
    cyc(0, 1, 0, 32'h8000_0003);
    chk("R2 load visible", status, 32'h3);
    cyc(0); cyc(0);
    chk("R3 hold without tick", status, 32'h3);
    cyc(1); cyc(1); cyc(0); cyc(1);
    chk("R3 three ticks down to zero", status, 32'h0);
    chk("R4 no irq before N+1 ticks", {31'b0, irq}, 32'h0);
    cyc(1);
    chk("R4 irq after N+1 ticks", {31'b0, irq}, 32'h1);
    cyc(1); cyc(1); cyc(0);
    chk("R6 one-shot stays at zero", status, 32'h8000_0000);
    chk("R10 irq held", {31'b0, irq}, 32'h1);
    cyc(0, 1, 1, 32'h0);
    chk("R8 clear with bit0=0 ignored", {31'b0, irq}, 32'h1);
    cyc(0, 1, 1, 32'h1);
    chk("R8 clear with bit0=1", {31'b0, irq}, 32'h0);
    cyc(1); cyc(1); cyc(1);
    chk("R6 no second expiry", status, 32'h0);

    // periodic, load 2
    cyc(0, 1, 0, 32'hC000_0002);
    cyc(1); cyc(1);
    chk("R5 periodic at zero", status, 32'h0);
    cyc(1);
    chk("R5 reload after expiry", status, 32'h8000_0002);
    cyc(0, 1, 1, 32'h1);
    chk("R8 cleared in periodic", {31'b0, irq}, 32'h0);
    cyc(1); cyc(1); cyc(1);
    chk("R5 second period expiry", status, 32'h8000_0002);
    // collision: pending, count 0, tick + clear same cycle
    cyc(1); cyc(1);
    chk("R9 setup count zero pending", status, 32'h8000_0000);
    cyc(1, 1, 1, 32'h1);
    chk("R9 expiry beats clear", {31'b0, irq}, 32'h1);
    chk("R9 reload during collision", status, 32'h8000_0002);
    cyc(0, 1, 1, 32'h1);

    // R12: control write with tick
    cyc(1, 1, 0, 32'hC000_0005);
    chk("R12 write beats tick", status, 32'h5);
    // R7 stop
    cyc(0, 1, 0, 32'h0);
    chk("R7 zero write stops", status, 32'h0);
    cyc(1); cyc(1); cyc(1);
    chk("R7 no expiry after stop", {31'b0, irq}, 32'h0);
    // R12 at count zero: write with tick prevents expiry
    cyc(0, 1, 0, 32'h8000_0000);
    cyc(1, 1, 0, 32'h8000_0001);
    chk("R12 no expiry on write cycle", {31'b0, irq}, 32'h0);

    // random traffic against model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3)
        cyc($urandom_range(0, 1), 1, 0,
            {1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b0,
             29'($urandom_range(0, 12))});
      else if (r < 8) cyc($urandom_range(0, 1), 1, 1, 32'($urandom_range(0, 1)));
      else cyc(r < 70);
    end
    finish_run();
  end
endmodule